// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the hardware part of taking an exception and coming back from it on a small 8-bit processor core. When the interrupt controller presents a request that the current mask state allows, the sequencer acknowledges it. It snapshots the programmer-visible registers and writes them as a nine-byte frame onto a byte-wide stack. It then reads a two-byte vector and, in one cycle, loads the new program counter, the lowered stack pointer and a condition code byte with its mask bits raised.

On a return-from-interrupt command the sequencer reads the same nine bytes back in reverse order. In the last read cycle it reloads every register, including both mask bits, exactly as they were before entry. The core keeps its own register file. The sequencer only reads it through the `cur_*` inputs and writes it through the `ld_*` strobes and `*_out` values. Memory reads are combinational: `mem_rdata` belongs to the address driven in the same cycle.

States:
- `ST_IDLE` waits.
- `ST_PUSH` runs for nine write cycles.
- `ST_VEC_HI` and `ST_VEC_LO` read the vector.
- `ST_POP` runs for nine read cycles.

Transitions:
- IDLE→POP on `ret_req`.
- IDLE→PUSH on an accepted request.
- PUSH→VEC_HI after the ninth write.
- VEC_HI→VEC_LO always.
- VEC_LO→IDLE always.
- POP→IDLE after the ninth read.

Top module: `irq_seq`

## Requirements
- R1: After reset `busy`, `req_ack`, `mem_we`, `mem_re` and every `ld_*` strobe are low.
- R2: A request of kind 0 (maskable) is acknowledged only when `insn_done` is 1 and bit 4 (the I mask) of `cur_ccr` is 0. `req_ack` is high combinationally in the accepting cycle.
- R3: A request of kind 1 (non-maskable) is acknowledged whenever bit 6 (the X mask) of `cur_ccr` is 0, whatever `insn_done` and the I bit are.
- R4: A request of kind 2 (software) is acknowledged when `insn_done` is 1, whatever the I and X bits are.
- R5: In the nine cycles after acceptance, `mem_we` is high, with addresses SP, SP-1, …, SP-8 (SP = `cur_sp` at acceptance). The data bytes in that order are: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR, all captured at acceptance.
- R6: Two read cycles follow: the first at the vector address V, the second at V+1. In the second one `ld_pc`, `ld_sp` and `ld_ccr` pulse, with PC = {byte at V, byte at V+1} and SP = SP-9.
- R7: The CCR loaded at entry equals the stacked CCR with bit 4 set. For kind 1, bit 6 is set as well. No other bit changes.
- R8: `busy` is high from the cycle after acceptance through the vector-load cycle (11 cycles) and low after it. While `busy` is high, no request is acknowledged.
- R9: `ret_req` in idle takes precedence over any request, which is then not acknowledged. It starts nine read cycles at SP+1 … SP+9 that fetch CCR, B, A, IX high, IX low, IY high, IY low, PC high, PC low.
- R10: In the ninth return read, `ld_pc`, `ld_gpr`, `ld_ccr` and `ld_sp` pulse together. The loaded values equal the register values before the matching entry, including bits 4 and 6 of the CCR and the stack pointer.
- R11: A request of kind 3 is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request from the interrupt controller |
| req_kind | input | 2 | 0 maskable, 1 non-maskable, 2 software, 3 none |
| req_vector | input | 16 | Even address of the chosen vector entry |
| insn_done | input | 1 | Instruction boundary reached |
| req_ack | output | 1 | Request accepted this cycle |
| ret_req | input | 1 | Start return-from-interrupt |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Stack byte write |
| mem_re | output | 1 | Byte read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the current address |
| cur_pc | input | 16 | Current program counter |
| cur_iy | input | 16 | Current IY |
| cur_ix | input | 16 | Current IX |
| cur_a | input | 8 | Current accumulator A |
| cur_b | input | 8 | Current accumulator B |
| cur_ccr | input | 8 | Current condition codes |
| cur_sp | input | 16 | Current stack pointer |
| ld_pc | output | 1 | Load `pc_out` |
| ld_ccr | output | 1 | Load `ccr_out` |
| ld_sp | output | 1 | Load `sp_out` |
| ld_gpr | output | 1 | Load A, B, IX, IY |
| pc_out | output | 16 | New PC |
| iy_out | output | 16 | Restored IY |
| ix_out | output | 16 | Restored IX |
| a_out | output | 8 | Restored A |
| b_out | output | 8 | Restored B |
| ccr_out | output | 8 | New CCR |
| sp_out | output | 16 | New SP |

## Verification
The acknowledge is combinational, so the bench reads it a moment after driving a request, still inside the same cycle. The k-th stack write (k = 0..8) is due k+1 cycles after acceptance, the vector reads at cycles 10 and 11, and `busy` falls in cycle 12. On return, the k-th read is due k+1 cycles after `ret_req` is seen, with all loads in cycle 9. The bench drives inputs on the falling edge and samples one nanosecond later, stepping exactly one falling edge per expected cycle. Each value is therefore compared in the cycle it is due, against frame bytes and vectors it predicts from its own register and memory model.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int FRAME_LEN  = 9;
    localparam int SLOT_W     = $clog2(FRAME_LEN);
    localparam int MASK_I_POS = 4;
    localparam int MASK_X_POS = 6;

    // frame slot index = push order (slot 0 lands at the entry stack pointer)
    localparam int SLOT_PCL = 0;
    localparam int SLOT_PCH = 1;
    localparam int SLOT_IYL = 2;
    localparam int SLOT_IYH = 3;
    localparam int SLOT_IXL = 4;
    localparam int SLOT_IXH = 5;
    localparam int SLOT_A   = 6;
    localparam int SLOT_B   = 7;
    localparam int SLOT_CCR = 8;

    typedef enum logic [1:0] {
        SRC_MASKABLE = 2'd0,
        SRC_NONMASK  = 2'd1,
        SRC_SOFT     = 2'd2,
        SRC_NONE     = 2'd3
    } src_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_POP
    } seq_state_e;
endpackage

// File: rtl/irq_seq_gate.sv
`timescale 1ns/1ps
module irq_seq_gate
    import irq_seq_pkg::*;
(
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              insn_done,
    input  logic [BYTE_W-1:0] ccr,
    output logic              take
);
    always_comb begin
        unique case (src_kind_e'(req_kind))
            SRC_MASKABLE: take = req_valid & insn_done & ~ccr[MASK_I_POS];
            SRC_NONMASK:  take = req_valid & ~ccr[MASK_X_POS];
            SRC_SOFT:     take = req_valid & insn_done;
            default:      take = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_seq_frame.sv
`timescale 1ns/1ps
module irq_seq_frame
    import irq_seq_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 capture,
    input  logic [FRAME_LEN-1:0][BYTE_W-1:0]     cap_bytes,
    input  logic                                 wr_en,
    input  logic [SLOT_W-1:0]                    wr_slot,
    input  logic [BYTE_W-1:0]                    wr_byte,
    input  logic [SLOT_W-1:0]                    rd_slot,
    output logic [BYTE_W-1:0]                    rd_byte,
    output logic [FRAME_LEN-1:0][BYTE_W-1:0]     all_bytes
);
    logic [FRAME_LEN-1:0][BYTE_W-1:0] slot_q;

    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (capture) begin
                slot_q[g] <= cap_bytes[g];
            end else if (wr_en && wr_slot == SLOT_W'(g)) begin
                slot_q[g] <= wr_byte;
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < FRAME_LEN; k++) begin
            if (rd_slot == SLOT_W'(k)) rd_byte = slot_q[k];
        end
    end

    assign all_bytes = slot_q;
endmodule

// File: rtl/irq_seq.sv
`timescale 1ns/1ps
module irq_seq
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] req_vector,
    input  logic              insn_done,
    output logic              req_ack,
    input  logic              ret_req,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [WORD_W-1:0] cur_iy,
    input  logic [WORD_W-1:0] cur_ix,
    input  logic [BYTE_W-1:0] cur_a,
    input  logic [BYTE_W-1:0] cur_b,
    input  logic [BYTE_W-1:0] cur_ccr,
    input  logic [WORD_W-1:0] cur_sp,
    output logic              ld_pc,
    output logic              ld_ccr,
    output logic              ld_sp,
    output logic              ld_gpr,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] iy_out,
    output logic [WORD_W-1:0] ix_out,
    output logic [BYTE_W-1:0] a_out,
    output logic [BYTE_W-1:0] b_out,
    output logic [BYTE_W-1:0] ccr_out,
    output logic [WORD_W-1:0] sp_out
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
    localparam logic [WORD_W-1:0] FRAME_SZ  = WORD_W'(FRAME_LEN);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] cnt_q, cnt_d;
    logic [WORD_W-1:0] sp_q, sp_d;
    logic [WORD_W-1:0] vec_q, vec_d;
    src_kind_e         kind_q, kind_d;
    logic [BYTE_W-1:0] hi_q, hi_d;

    logic                             take;
    logic                             frm_capture;
    logic                             frm_wr;
    logic [SLOT_W-1:0]                frm_wr_slot;
    logic [SLOT_W-1:0]                frm_rd_slot;
    logic [BYTE_W-1:0]                frm_rd_byte;
    logic [FRAME_LEN-1:0][BYTE_W-1:0] frm_bytes;
    logic [FRAME_LEN-1:0][BYTE_W-1:0] snap;

    assign snap = {cur_ccr, cur_b, cur_a, cur_ix[15:8], cur_ix[7:0],
                   cur_iy[15:8], cur_iy[7:0], cur_pc[15:8], cur_pc[7:0]};

    irq_seq_gate u_gate (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .insn_done (insn_done),
        .ccr       (cur_ccr),
        .take      (take)
    );

    irq_seq_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (frm_capture),
        .cap_bytes (snap),
        .wr_en     (frm_wr),
        .wr_slot   (frm_wr_slot),
        .wr_byte   (mem_rdata),
        .rd_slot   (frm_rd_slot),
        .rd_byte   (frm_rd_byte),
        .all_bytes (frm_bytes)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sp_q    <= '0;
            vec_q   <= '0;
            kind_q  <= SRC_NONE;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sp_q    <= sp_d;
            vec_q   <= vec_d;
            kind_q  <= kind_d;
            hi_q    <= hi_d;
        end
    end

    assign busy = (state_q != ST_IDLE);

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        sp_d        = sp_q;
        vec_d       = vec_q;
        kind_d      = kind_q;
        hi_d        = hi_q;
        req_ack     = 1'b0;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        frm_capture = 1'b0;
        frm_wr      = 1'b0;
        frm_wr_slot = '0;
        frm_rd_slot = '0;
        ld_pc       = 1'b0;
        ld_ccr      = 1'b0;
        ld_sp       = 1'b0;
        ld_gpr      = 1'b0;
        pc_out      = '0;
        iy_out      = '0;
        ix_out      = '0;
        a_out       = '0;
        b_out       = '0;
        ccr_out     = '0;
        sp_out      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_req) begin
                    state_d = ST_POP;
                    cnt_d   = '0;
                    sp_d    = cur_sp;
                end else if (take) begin
                    req_ack     = 1'b1;
                    frm_capture = 1'b1;
                    sp_d        = cur_sp;
                    vec_d       = req_vector;
                    kind_d      = src_kind_e'(req_kind);
                    cnt_d       = '0;
                    state_d     = ST_PUSH;
                end
            end
            ST_PUSH: begin
                mem_we      = 1'b1;
                mem_addr    = sp_q - WORD_W'(cnt_q);
                frm_rd_slot = cnt_q;
                mem_wdata   = frm_rd_byte;
                if (cnt_q == LAST_SLOT) state_d = ST_VEC_HI;
                else                    cnt_d   = cnt_q + SLOT_W'(1);
            end
            ST_VEC_HI: begin
                mem_re   = 1'b1;
                mem_addr = vec_q;
                hi_d     = mem_rdata;
                state_d  = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                mem_re   = 1'b1;
                mem_addr = vec_q + WORD_W'(1);
                ld_pc    = 1'b1;
                pc_out   = {hi_q, mem_rdata};
                ld_sp    = 1'b1;
                sp_out   = sp_q - FRAME_SZ;
                ld_ccr   = 1'b1;
                ccr_out  = frm_bytes[SLOT_CCR];
                ccr_out[MASK_I_POS] = 1'b1;
                if (kind_q == SRC_NONMASK) ccr_out[MASK_X_POS] = 1'b1;
                state_d  = ST_IDLE;
            end
            ST_POP: begin
                mem_re      = 1'b1;
                mem_addr    = sp_q + WORD_W'(cnt_q) + WORD_W'(1);
                frm_wr      = 1'b1;
                frm_wr_slot = LAST_SLOT - cnt_q;
                if (cnt_q == LAST_SLOT) begin
                    ld_pc   = 1'b1;
                    ld_gpr  = 1'b1;
                    ld_ccr  = 1'b1;
                    ld_sp   = 1'b1;
                    pc_out  = {frm_bytes[SLOT_PCH], mem_rdata};
                    iy_out  = {frm_bytes[SLOT_IYH], frm_bytes[SLOT_IYL]};
                    ix_out  = {frm_bytes[SLOT_IXH], frm_bytes[SLOT_IXL]};
                    a_out   = frm_bytes[SLOT_A];
                    b_out   = frm_bytes[SLOT_B];
                    ccr_out = frm_bytes[SLOT_CCR];
                    sp_out  = sp_q + FRAME_SZ;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + SLOT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/irq_seq_chk.sv
`timescale 1ns/1ps
module irq_seq_chk
    import irq_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        req_kind,
    input logic              insn_done,
    input logic              req_ack,
    input logic              busy,
    input logic              mem_we,
    input logic              mem_re,
    input logic [WORD_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] cur_ccr,
    input logic              ld_pc,
    input logic              ld_gpr,
    input logic              ld_ccr,
    input logic              ld_sp,
    input logic [BYTE_W-1:0] ccr_out
);
    // R2
    maskable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_kind == 2'd0) |-> (insn_done && !cur_ccr[MASK_I_POS]));

    // R3
    nonmask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_kind == 2'd1) |-> !cur_ccr[MASK_X_POS]);

    // R4
    soft_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_kind == 2'd2) |-> insn_done);

    // R11
    no_kind3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (req_kind != 2'd3));

    // R8
    ack_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy);

    // R8
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ack);

    // R5
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    // R5
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6
    vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pc && !ld_gpr) |-> (mem_re && $past(mem_re) && mem_addr == $past(mem_addr) + 16'd1));

    // R7
    entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ccr && !ld_gpr) |-> ccr_out[MASK_I_POS]);

    // R8
    end_of_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pc && !ld_gpr) |=> !busy);

    // R9
    pop_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re) && !ld_pc) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R10
    restore_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_gpr |-> (ld_pc && ld_ccr && ld_sp && busy));
endmodule

bind irq_seq irq_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_kind  (req_kind),
    .insn_done (insn_done),
    .req_ack   (req_ack),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .cur_ccr   (cur_ccr),
    .ld_pc     (ld_pc),
    .ld_gpr    (ld_gpr),
    .ld_ccr    (ld_ccr),
    .ld_sp     (ld_sp),
    .ccr_out   (ccr_out)
);

// File: tb/tb_irq_seq.sv
`timescale 1ns/1ps
module tb_irq_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_vector = 16'hFFF0;
    logic        insn_done = 1'b0;
    logic        req_ack;
    logic        ret_req = 1'b0;
    logic        busy, mem_we, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] r_pc = 16'h0, r_iy = 16'h0, r_ix = 16'h0, r_sp = 16'h0080;
    logic [7:0]  r_a = 8'h0, r_b = 8'h0, r_ccr = 8'h0;
    logic        ld_pc, ld_ccr, ld_sp, ld_gpr;
    logic [15:0] pc_out, iy_out, ix_out, sp_out;
    logic [7:0]  a_out, b_out, ccr_out;

    logic [7:0] mem [256];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    irq_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_vector(req_vector), .insn_done(insn_done), .req_ack(req_ack),
        .ret_req(ret_req), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cur_pc(r_pc), .cur_iy(r_iy), .cur_ix(r_ix), .cur_a(r_a), .cur_b(r_b),
        .cur_ccr(r_ccr), .cur_sp(r_sp), .ld_pc(ld_pc), .ld_ccr(ld_ccr),
        .ld_sp(ld_sp), .ld_gpr(ld_gpr), .pc_out(pc_out), .iy_out(iy_out),
        .ix_out(ix_out), .a_out(a_out), .b_out(b_out), .ccr_out(ccr_out),
        .sp_out(sp_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [1:0] kind, input logic done,
                                    input logic [7:0] ccr);
        case (kind)
            2'd0:    return done && !ccr[4];
            2'd1:    return !ccr[6];
            2'd2:    return done;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string kind_tag(input logic [1:0] kind);
        case (kind)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic run_entry(input logic [1:0] kind, input logic [15:0] vec);
        logic [7:0]  fb [9];
        logic [15:0] sp0;
        logic [7:0]  ccr_exp;
        fb[0] = r_pc[7:0];  fb[1] = r_pc[15:8];
        fb[2] = r_iy[7:0];  fb[3] = r_iy[15:8];
        fb[4] = r_ix[7:0];  fb[5] = r_ix[15:8];
        fb[6] = r_a;        fb[7] = r_b;        fb[8] = r_ccr;
        sp0 = r_sp;
        ccr_exp = r_ccr | 8'h10 | ((kind == 2'd1) ? 8'h40 : 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_vector = vec;
        #1 chk(kind_tag(kind), "req_ack on allowed request", 32'(req_ack), 32'd1);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); #1;
            chk("R8", "busy during push", 32'(busy), 32'd1);
            chk("R8", "no ack while busy", 32'(req_ack), 32'd0);
            chk("R5", "push write strobe", 32'(mem_we), 32'd1);
            chk("R5", "push address", 32'(mem_addr), 32'(sp0 - 16'(i)));
            chk("R5", "push byte", 32'(mem_wdata), 32'(fb[i]));
            req_valid = 1'b1; req_kind = 2'd1; insn_done = 1'b1;
        end
        @(negedge clk); #1;
        chk("R6", "vector high read", 32'(mem_re), 32'd1);
        chk("R6", "vector high address", 32'(mem_addr), 32'(vec));
        chk("R8", "no ack in vector read", 32'(req_ack), 32'd0);
        @(negedge clk); #1;
        chk("R6", "ld_pc", 32'(ld_pc), 32'd1);
        chk("R6", "vector low address", 32'(mem_addr), 32'(vec + 16'd1));
        chk("R6", "new pc", 32'(pc_out), 32'({mem[vec[7:0]], mem[vec[7:0] + 8'd1]}));
        chk("R6", "new sp", 32'({ld_sp, sp_out}), 32'({1'b1, sp0 - 16'd9}));
        chk("R6", "no gpr load on entry", 32'(ld_gpr), 32'd0);
        chk("R7", "new ccr", 32'({ld_ccr, ccr_out}), 32'({1'b1, ccr_exp}));
        chk("R8", "busy in load cycle", 32'(busy), 32'd1);
        req_valid = 1'b0;
        r_pc = pc_out; r_sp = sp_out; r_ccr = ccr_out;
        @(negedge clk); #1;
        chk("R8", "busy released", 32'(busy), 32'd0);
    endtask

    task automatic run_return(input logic [15:0] e_pc, input logic [15:0] e_iy,
                              input logic [15:0] e_ix, input logic [7:0] e_a,
                              input logic [7:0] e_b, input logic [7:0] e_ccr,
                              input logic [15:0] e_sp);
        logic [15:0] sp1;
        sp1 = r_sp;
        @(negedge clk);
        ret_req = 1'b1; req_valid = 1'b1; req_kind = 2'd2; insn_done = 1'b1;
        #1 chk("R9", "return beats request", 32'(req_ack), 32'd0);
        for (int c = 0; c < 9; c++) begin
            @(negedge clk); #1;
            ret_req = 1'b0; req_valid = 1'b0;
            chk("R9", "pop read strobe", 32'({mem_re, mem_we}), 32'd2);
            chk("R9", "pop address", 32'(mem_addr), 32'(sp1 + 16'(c) + 16'd1));
            if (c < 8) chk("R10", "no early load", 32'(ld_pc), 32'd0);
        end
        chk("R10", "load strobes", 32'({ld_pc, ld_gpr, ld_ccr, ld_sp}), 32'hF);
        chk("R10", "restored pc", 32'(pc_out), 32'(e_pc));
        chk("R10", "restored iy", 32'(iy_out), 32'(e_iy));
        chk("R10", "restored ix", 32'(ix_out), 32'(e_ix));
        chk("R10", "restored a/b", 32'({a_out, b_out}), 32'({e_a, e_b}));
        chk("R10", "restored ccr incl masks", 32'(ccr_out), 32'(e_ccr));
        chk("R10", "restored sp", 32'(sp_out), 32'(e_sp));
        r_pc = pc_out; r_iy = iy_out; r_ix = ix_out; r_a = a_out; r_b = b_out;
        r_ccr = ccr_out; r_sp = sp_out;
        @(negedge clk); #1;
        chk("R9", "idle after return", 32'(busy), 32'd0);
    endtask

    task automatic try_reject(input logic [1:0] kind, input logic done);
        string t;
        t = kind_tag(kind);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; insn_done = done;
        #1 chk(t, "no ack on blocked request", 32'(req_ack), 32'd0);
        @(negedge clk); #1;
        chk(t, "stays idle", 32'({busy, mem_we, mem_re}), 32'd0);
        req_valid = 1'b0;
    endtask

    task automatic round_trip(input logic [1:0] kind, input logic [15:0] vec);
        logic [15:0] s_pc, s_iy, s_ix, s_sp;
        logic [7:0]  s_a, s_b, s_ccr;
        s_pc = r_pc; s_iy = r_iy; s_ix = r_ix; s_sp = r_sp;
        s_a = r_a; s_b = r_b; s_ccr = r_ccr;
        run_entry(kind, vec);
        run_return(s_pc, s_iy, s_ix, s_a, s_b, s_ccr, s_sp);
    endtask

    task automatic rand_regs();
        r_pc  = 16'($urandom);
        r_iy  = 16'($urandom);
        r_ix  = 16'($urandom);
        r_a   = 8'($urandom);
        r_b   = 8'($urandom);
        r_ccr = 8'($urandom);
        r_sp  = {8'($urandom), 8'(8'h30 + 8'($urandom % 160))};
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk("R1", "reset outputs",
            32'({busy, req_ack, mem_we, mem_re, ld_pc, ld_ccr, ld_sp, ld_gpr}), 32'd0);
        rst_n = 1'b1;

        // R2 blocked by I mask and by missing boundary
        r_ccr = 8'h10; try_reject(2'd0, 1'b1);
        r_ccr = 8'h00; try_reject(2'd0, 1'b0);
        // R3 blocked by X mask
        r_ccr = 8'h40; try_reject(2'd1, 1'b1);
        // R11 kind 3 with everything open
        r_ccr = 8'h00; try_reject(2'd3, 1'b1);

        // R2 accepted maskable
        rand_regs(); r_ccr = 8'hA5 & 8'hAF; insn_done = 1'b1;
        round_trip(2'd0, 16'hFFF2);
        // R3 non-maskable mid-instruction with I set
        rand_regs(); r_ccr = 8'h1B; insn_done = 1'b0;
        round_trip(2'd1, 16'hFFF4);
        // R4 software with both masks set
        rand_regs(); r_ccr = 8'h53; insn_done = 1'b1;
        round_trip(2'd2, 16'hFFFA);

        for (int it = 0; it < 60; it++) begin
            logic [1:0]  kind;
            logic        done;
            logic [15:0] vec;
            rand_regs();
            kind = 2'($urandom % 4);
            done = 1'($urandom);
            vec  = 16'hFFF0 | 16'(($urandom % 8) * 2);
            insn_done = done;
            if (exp_take(kind, done, r_ccr)) round_trip(kind, vec);
            else                             try_reject(kind, done);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule